// File: doc/BRIEF.md
# Serial Character Transmitter with Line Break

This block turns 8-bit characters into asynchronous serial frames on a single output line. Characters arrive on a valid/ready handshake and wait in a one-entry holding stage. The shift stage takes each character from there and sends it. The frame layout is chosen per character through static format inputs:
- five to eight data bits;
- parity that is off, odd, even, constant one or constant zero;
- one or two stop bits.

The format is captured when a character moves into the shift stage, so a format change never disturbs a frame that is already on the wire.

Bit timing comes from an external baud tick. Every bit lasts a fixed number of ticks. An enable input gates the start of each new character; a character already under way is always finished. A break input drives the line low at once, whatever the transmitter is doing, while the frame sequencing goes on unseen underneath. Two status outputs tell the host whether the holding stage is free and whether the whole transmitter has drained.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame starts with one low bit, followed by the data bits least significant first, then the parity bit when parity is on, then the stop bits at high level.
- R2: `word_len` selects the data width as 5 + `word_len` bits (00=5, 01=6, 10=7, 11=8). Input bits above that width are not sent and do not enter the parity.
- R3: `two_stop`=0 sends one stop bit; `two_stop`=1 sends two stop bits.
- R4: With `par_on`=1, `par_mode` picks the parity bit: 00 makes the count of ones in data plus parity odd, 01 makes it even, 10 sends constant 1, 11 sends constant 0. With `par_on`=0 no parity bit is sent.
- R5: Every bit lasts exactly 16 baud ticks. `txd` is high after reset and between frames.
- R6: While `brk_force` is 1, `txd` is 0 from the next clock on, in any state. Frame sequencing keeps running, so a frame that was under way still completes on time.
- R7: While `xmit_en` is 0, no new character is started and a waiting character stays in the holding stage.
- R8: Clearing `xmit_en` during a character lets that character finish. The next character waits until `xmit_en` returns to 1.
- R9: `in_ready` and `hold_empty` are 1 exactly when the holding stage is free. A character is taken on a clock where `in_valid` and `in_ready` are both 1, and `hold_empty` is 0 on the following cycle.
- R10: `tx_empty` is 1 only when both the holding stage and the shift stage are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character value |
| in_ready | output | 1 | Holding stage can take a character |
| xmit_en | input | 1 | Allows a new character to start |
| brk_force | input | 1 | Forces the line low |
| word_len | input | 2 | Data width code (5 + value bits) |
| two_stop | input | 1 | 1 selects two stop bits |
| par_on | input | 1 | Enables the parity bit |
| par_mode | input | 2 | Parity kind: odd, even, one, zero |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding stage free |
| tx_empty | output | 1 | Holding and shift stages both empty |

## Verification
A wrong tick count inside a bit shows up on the line within one bit time. The next mid-bit sample lands on the neighbouring bit, so the scoreboard's frame comparison fails on that same frame. A shift image or length that is wrong for the chosen format shows as a wrong parity position or a missing stop bit in the first frame sent with that format. A holding flag that does not clear or set shows at `in_ready` and the two empty flags one clock after the handshake or the load. A start gate that leaks shows as a falling edge on `txd` while the enable is low.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam int DATA_W    = 8;
  localparam int FRAME_MAX = 1 + DATA_W + 1 + 2;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ONE   = 2'b10,
    PAR_ZERO  = 2'b11
  } par_kind_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    par_kind_e  par_kind;
  } fmt_t;

  function automatic logic [LEN_W-1:0] data_bits(logic [1:0] wlen);
    return LEN_W'(5) + LEN_W'(wlen);
  endfunction

  function automatic logic [DATA_W-1:0] mask_data(logic [DATA_W-1:0] d, logic [1:0] wlen);
    logic [DATA_W-1:0] m;
    m = {DATA_W{1'b1}} >> (2'd3 - wlen);
    return d & m;
  endfunction

  function automatic logic parity_bit(logic [DATA_W-1:0] md, par_kind_e k);
    logic p;
    case (k)
      PAR_ODD:  p = ~(^md);
      PAR_EVEN: p = ^md;
      PAR_ONE:  p = 1'b1;
      default:  p = 1'b0;
    endcase
    return p;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(fmt_t f);
    return LEN_W'(2) + data_bits(f.wlen) + LEN_W'(f.par_en) + LEN_W'(f.stop2);
  endfunction

  function automatic logic [FRAME_MAX-1:0] build_frame(logic [DATA_W-1:0] d, fmt_t f);
    logic [FRAME_MAX-1:0] fr;
    logic [DATA_W-1:0]    md;
    logic [LEN_W-1:0]     n;
    md = mask_data(d, f.wlen);
    n  = data_bits(f.wlen);
    fr = {FRAME_MAX{1'b1}};
    fr[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) < n) fr[i+1] = md[i];
    end
    if (f.par_en) fr[n + LEN_W'(1)] = parity_bit(md, f.par_kind);
    return fr;
  endfunction

endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (push) begin
      full <= 1'b1;
      dout <= din;
    end else if (pop) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [CW-1:0] cnt;

  assign bit_end = run & tick & (cnt == CW'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (run & tick) cnt <= bit_end ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [LEN_W-1:0]     len,
  input  logic                 bit_end,
  output logic                 busy,
  output logic                 line
);
  logic [FRAME_MAX-1:0] sh;
  logic [LEN_W-1:0]     left;
  logic                 last_bit;

  assign last_bit = busy & (left == LEN_W'(1));
  assign line     = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= frame;
      left <= len;
      busy <= 1'b1;
    end else if (busy & bit_end) begin
      sh   <= {1'b1, sh[FRAME_MAX-1:1]};
      left <= left - LEN_W'(1);
      if (last_bit) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import utx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              xmit_en,
  input  logic              brk_force,
  input  logic [1:0]        word_len,
  input  logic              two_stop,
  input  logic              par_on,
  input  logic [1:0]        par_mode,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);
  fmt_t              fmt;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              accept;
  logic              ld_go;
  logic              sh_busy;
  logic              sh_line;
  logic              bit_end;
  logic              txd_q;

  assign fmt.wlen     = word_len;
  assign fmt.stop2    = two_stop;
  assign fmt.par_en   = par_on;
  assign fmt.par_kind = par_kind_e'(par_mode);

  assign accept = in_valid & ~hold_full;
  assign ld_go  = hold_full & ~sh_busy & xmit_en;

  utx_hold #(.W(DATA_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .push (accept),
    .pop  (ld_go),
    .din  (in_data),
    .full (hold_full),
    .dout (hold_data)
  );

  utx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ld_go),
    .run    (sh_busy),
    .tick   (baud_tick),
    .bit_end(bit_end)
  );

  utx_shifter u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ld_go),
    .frame  (build_frame(hold_data, fmt)),
    .len    (frame_len(fmt)),
    .bit_end(bit_end),
    .busy   (sh_busy),
    .line   (sh_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) txd_q <= 1'b1;
    else        txd_q <= brk_force ? 1'b0 : sh_line;
  end

  assign txd        = txd_q;
  assign in_ready   = ~hold_full;
  assign hold_empty = ~hold_full;
  assign tx_empty   = ~hold_full & ~sh_busy;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic in_valid,
  input logic in_ready,
  input logic xmit_en,
  input logic brk_force,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty,
  input logic busy
);
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !brk_force |=> !txd);                              // R1
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_force && !busy |=> txd);                                     // R5
  AST_TICK_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !baud_tick |=> busy);                                     // R5
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_force |=> !txd);                                              // R6
  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !xmit_en && !busy |=> !busy);                                     // R7
  AST_GATE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !xmit_en && !busy && !hold_empty |=> !hold_empty);                // R7
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !hold_empty);                            // R9
  AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty && !busy);                                // R10
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .xmit_en   (xmit_en),
  .brk_force (brk_force),
  .txd       (txd),
  .hold_empty(hold_empty),
  .tx_empty  (tx_empty),
  .busy      (sh_busy)
);

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/100ps
module uart_frame_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       xmit_en = 1'b1;
  logic       brk_force = 1'b0;
  logic [1:0] word_len = 2'b11;
  logic       two_stop = 1'b0;
  logic       par_on = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic       txd;
  logic       hold_empty;
  logic       tx_empty;

  int n_checks = 0;
  int n_fail = 0;
  int frames_seen = 0;
  bit mon_en = 1'b1;
  bit cap_busy = 1'b0;

  typedef struct {
    logic [11:0] bits;
    int          len;
    logic [7:0]  d;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  always @(negedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

  uart_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .xmit_en(xmit_en), .brk_force(brk_force), .word_len(word_len),
    .two_stop(two_stop), .par_on(par_on), .par_mode(par_mode),
    .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  task automatic check(bit ok, string req, int got, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=0x%0h expected=0x%0h t=%0t", req, got, exp, $time);
    end
  endtask

  // Expected frame, built as a bit list in line order
  function automatic exp_t make_exp(logic [7:0] d);
    exp_t e;
    int n, ones, k;
    n = 5 + int'(word_len);
    e.d = d; e.bits = '1; ones = 0; k = 0;
    e.bits[k++] = 1'b0;
    for (int i = 0; i < n; i++) begin
      e.bits[k++] = d[i];
      if (d[i]) ones++;
    end
    if (par_on) begin
      case (par_mode)
        2'b00: e.bits[k++] = (ones % 2 == 0);
        2'b01: e.bits[k++] = (ones % 2 == 1);
        2'b10: e.bits[k++] = 1'b1;
        default: e.bits[k++] = 1'b0;
      endcase
    end
    e.bits[k++] = 1'b1;
    if (two_stop) e.bits[k++] = 1'b1;
    e.len = k;
    return e;
  endfunction

  task automatic send(logic [7:0] d, bit keep);
    if (keep) exp_q.push_back(make_exp(d));
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic capture();
    exp_t e;
    logic [11:0] got;
    int cnt, k;
    cap_busy = 1'b1;
    frames_seen++;
    if (exp_q.size() == 0) begin
      check(1'b0, "R1 unexpected frame", 1, 0);
    end else begin
      e = exp_q.pop_front();
      got = '1; cnt = 0; k = 0;
      while (k < e.len) begin
        @(posedge clk); #1;
        if (baud_tick) begin
          cnt++;
          if (cnt == 8 + 16 * k) begin got[k] = txd; k++; end
        end
      end
      check(got == e.bits, "R1/R2/R3/R4/R5 frame bits", int'(got), int'(e.bits));
    end
    cap_busy = 1'b0;
  endtask

  initial begin : monitor
    logic prev;
    prev = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (mon_en && prev && !txd) capture();
      prev = txd;
    end
  end

  task automatic wait_done();
    int t;
    t = 0;
    do begin @(negedge clk); t++; end
    while ((exp_q.size() != 0 || !tx_empty || cap_busy) && t < 20000);
    repeat (40) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : main
    int bad, t, f0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R5 idle line after reset", txd, 1);
    check(hold_empty && in_ready, "R9 holding free after reset", hold_empty, 1);
    check(tx_empty == 1'b1, "R10 empty after reset", tx_empty, 1);

    // R1 R5: plain 8 data, no parity, 1 stop
    send(8'hA5, 1); send(8'h3C, 1); send(8'h01, 1);
    wait_done();

    // R2 R3 R4: sweep of formats; upper bits set to show they are dropped
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 5; p++) begin
        word_len = w[1:0];
        par_on   = (p != 4);
        par_mode = p[1:0];
        two_stop = w[0] ^ p[0];
        send(8'hE5, 1); send(8'h9A, 1); send(8'hF0, 1);
        wait_done();
      end
    end
    check(exp_q.size() == 0, "R2 all format frames seen", exp_q.size(), 0);
    word_len = 2'b11; par_on = 1'b0; two_stop = 1'b0;

    // R9 R10: status around a handshake
    exp_q.push_back(make_exp(8'h6B));
    @(negedge clk); in_valid = 1'b1; in_data = 8'h6B;
    @(negedge clk); in_valid = 1'b0;
    check(hold_empty == 1'b0 && in_ready == 1'b0, "R9 holding full after take", hold_empty, 0);
    check(tx_empty == 1'b0, "R10 not empty with holding full", tx_empty, 0);
    @(negedge clk);
    check(hold_empty == 1'b1, "R9 holding free after load", hold_empty, 1);
    check(tx_empty == 1'b0, "R10 not empty while shifting", tx_empty, 0);
    wait_done();

    // R7: gate closed, character waits
    xmit_en = 1'b0;
    send(8'h55, 1);
    bad = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!txd || hold_empty || tx_empty) bad++;
    end
    check(bad == 0, "R7 no start while gated", bad, 0);
    xmit_en = 1'b1;
    wait_done();
    check(exp_q.size() == 0, "R7 waiting character sent after enable", exp_q.size(), 0);

    // R8: gate cleared mid-character
    f0 = frames_seen;
    send(8'h12, 1); send(8'h34, 1);
    repeat (20) @(negedge clk);
    xmit_en = 1'b0;
    repeat (600) @(negedge clk);
    check(frames_seen == f0 + 1, "R8 current frame finished", frames_seen - f0, 1);
    check(hold_empty == 1'b0 && txd == 1'b1, "R8 next character held", hold_empty, 0);
    xmit_en = 1'b1;
    wait_done();
    check(frames_seen == f0 + 2, "R8 held frame sent later", frames_seen - f0, 2);

    // R6: break at idle
    mon_en = 1'b0;
    @(negedge clk); brk_force = 1'b1;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (txd) bad++; end
    check(bad == 0, "R6 break holds line low at idle", bad, 0);
    brk_force = 1'b0;
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R6 line high after break", txd, 1);

    // R6: break over a frame; frame still ends on time (10 bits * 32 cycles)
    send(8'hFF, 0);
    repeat (60) @(negedge clk);
    brk_force = 1'b1;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (txd) bad++; end
    check(bad == 0, "R6 break overrides frame", bad, 0);
    brk_force = 1'b0;
    t = 0;
    while (!tx_empty && t < 1000) begin @(negedge clk); t++; end
    check(t > 100 && t < 200, "R6 frame timing kept under break", t, 150);
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R5 line idle after frame", txd, 1);
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R5: final frame with two stops after the break
    two_stop = 1'b1;
    send(8'hC3, 1);
    wait_done();
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule